// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Controller

This block is the device side of a three-wire serial EEPROM that holds 128 words of 16 bits. It watches a chip-select, a serial clock and a serial data input, all sampled into the system clock domain. It assembles each command frame from them: a start bit, a two-bit opcode and eight address slots. It also keeps a write-enable latch that guards every command able to change the array.

Commands that alter the array are single-word erase, erase-all and a word-write stub. They are never committed on a serial clock edge. They commit on the falling edge of chip-select that follows a complete frame, and only if the latch is set. A committed command starts a self-timed busy period whose length is a parameter in system clocks. During that period all new commands are ignored. If the host raises chip-select again, the serial output reports busy as 0 and ready as 1. A read stub shifts a stored word out, so the bench can observe the array.

The serial output is modelled as a data bit plus an output-enable. The output is undriven whenever chip-select is low and while a command is being clocked in.

Top module: `uw_eeprom_ctrl`

## Requirements
- R1: After reset the write-enable latch is clear, and erase, erase-all and write commands leave the array unchanged and start no busy period until a write-enable command has been accepted.
- R2: A frame begins at the first serial clock rising edge that samples di=1 (earlier 0 bits are skipped). It then takes a two-bit opcode (first bit is the MSB) and eight address slots, MSB first, for 11 rising edges in total.
- R3: Opcode 00 with the first two address slots 11 sets the latch, and with 00 clears it. The other six slots are don't-care. The latch holds its value until a clearing command or reset.
- R4: Opcode 00 with the first two address slots 10 (erase-all) sets every word to 16'hFFFF.
- R5: Opcode 11 (erase) sets the addressed word to 16'hFFFF and leaves the other words unchanged.
- R6: Array changes and latch changes take effect only on the falling edge of cs that follows a complete frame, never on a serial clock edge.
- R7: If cs falls before a frame is complete, the partial command is dropped and no state changes.
- R8: When cs is raised after a committed array change, do is driven: 0 while the busy period lasts and 1 once it has ended. The busy period lasts ERASE_CYCLES system clocks.
- R9: do_oe is 0 while cs is low and while a command frame is being clocked in.
- R10: Address slot A7 is ignored, so addresses wrap onto 7 bits.
- R11: Opcode 10 (read) works whatever the latch state. After the last address bit, do is driven with a dummy 0. Each further rising edge then presents the next data bit, D15 first.
- R12: Start bits and commands that arrive during the busy period are ignored.
- R13: Opcode 01 (write) takes 16 data bits MSB first after the address. A complete frame is programmed at the fall of cs if the latch is set. The array resets to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip-select, active high |
| sk | input | 1 | Serial clock; bits are taken on its rising edge |
| di | input | 1 | Serial data in |
| do_bit | output | 1 | Serial data / ready-busy status out |
| do_oe | output | 1 | Output enable for do_bit; 0 means high impedance |

## Verification
The assertions assume that sk, di and cs change slowly compared with clk. Each level must persist for several system clocks, so the synchroniser produces one edge pulse per transition. They also assume that cs is not toggled in the same cycle as an sk edge. The bench keeps every serial half period at eight system clocks. It changes cs only while sk is low and several clocks away from any sk edge. It drives all inputs on the falling edge of clk. Random opcode, address and data values are drawn from a fixed seed. All of them stay inside these timing limits.

// File: rtl/uw_pkg.sv
package uw_pkg;
  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } uw_op_e;

  typedef enum logic [1:0] {
    EXT_LOCK   = 2'b00,
    EXT_FILL   = 2'b01,
    EXT_WIPE   = 2'b10,
    EXT_UNLOCK = 2'b11
  } uw_ext_e;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_ERASE_ONE,
    ACT_ERASE_ALL,
    ACT_WRITE
  } uw_act_e;
endpackage

// File: rtl/uw_pin_sync.sv
module uw_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic cs_o,
  output logic di_o,
  output logic sk_rise,
  output logic cs_rise,
  output logic cs_fall
);
  logic [STAGES-1:0] cs_pipe, sk_pipe, di_pipe;
  logic cs_d, sk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_pipe <= '0;
      sk_pipe <= '0;
      di_pipe <= '0;
      cs_d    <= 1'b0;
      sk_d    <= 1'b0;
    end else begin
      cs_pipe <= {cs_pipe[STAGES-2:0], cs_i};
      sk_pipe <= {sk_pipe[STAGES-2:0], sk_i};
      di_pipe <= {di_pipe[STAGES-2:0], di_i};
      cs_d    <= cs_pipe[STAGES-1];
      sk_d    <= sk_pipe[STAGES-1];
    end
  end

  assign cs_o    = cs_pipe[STAGES-1];
  assign di_o    = di_pipe[STAGES-1];
  assign sk_rise = sk_pipe[STAGES-1] & ~sk_d;
  assign cs_rise = cs_pipe[STAGES-1] & ~cs_d;
  assign cs_fall = ~cs_pipe[STAGES-1] & cs_d;
endmodule

// File: rtl/uw_frame_rx.sv
module uw_frame_rx
  import uw_pkg::*;
#(
  parameter int ADDR_SLOTS = 8,
  parameter int DW         = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_s,
  input  logic                  sk_rise,
  input  logic                  di_s,
  input  logic                  busy,
  input  logic [DW-1:0]         rd_word,
  output logic                  frame_done,
  output uw_op_e                op,
  output logic [ADDR_SLOTS-1:0] field,
  output logic [DW-1:0]         wdata,
  output logic                  start_seen,
  output logic                  rd_active,
  output logic                  rd_bit
);
  localparam int HDR_W    = 2 + ADDR_SLOTS;
  localparam int HDR_LEN  = 1 + HDR_W;
  localparam int FULL_LEN = HDR_LEN + DW;
  localparam int CW       = $clog2(FULL_LEN + 1);

  logic [CW-1:0]    cnt;
  logic [HDR_W-1:0] hdr;
  logic [DW-1:0]    rd_sr;
  logic             rd_load;
  uw_op_e           op_next;

  assign op      = uw_op_e'(hdr[HDR_W-1 -: 2]);
  assign op_next = uw_op_e'(hdr[HDR_W-2 -: 2]);
  assign field   = hdr[ADDR_SLOTS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      hdr        <= '0;
      wdata      <= '0;
      rd_sr      <= '0;
      rd_load    <= 1'b0;
      rd_active  <= 1'b0;
      rd_bit     <= 1'b0;
      start_seen <= 1'b0;
    end else begin
      start_seen <= 1'b0;
      rd_load    <= 1'b0;
      if (!cs_s) begin
        cnt       <= '0;
        rd_active <= 1'b0;
      end else if (sk_rise && !busy) begin
        if (cnt == '0) begin
          if (di_s) begin
            cnt        <= CW'(1);
            start_seen <= 1'b1;
          end
        end else if (cnt < CW'(HDR_LEN)) begin
          hdr <= {hdr[HDR_W-2:0], di_s};
          cnt <= cnt + CW'(1);
          if (cnt == CW'(HDR_LEN - 1) && op_next == OP_READ) rd_load <= 1'b1;
        end else if (op == OP_WRITE && cnt < CW'(FULL_LEN)) begin
          wdata <= {wdata[DW-2:0], di_s};
          cnt   <= cnt + CW'(1);
        end else if (rd_active) begin
          rd_bit <= rd_sr[DW-1];
          rd_sr  <= {rd_sr[DW-2:0], 1'b0};
        end
      end
      if (rd_load && cs_s) begin
        rd_sr     <= rd_word;
        rd_active <= 1'b1;
        rd_bit    <= 1'b0;
      end
    end
  end

  assign frame_done = (op != OP_WRITE && cnt == CW'(HDR_LEN)) ||
                      (op == OP_WRITE && cnt == CW'(FULL_LEN));
endmodule

// File: rtl/uw_cmd_exec.sv
module uw_cmd_exec
  import uw_pkg::*;
#(
  parameter int ADDR_SLOTS = 8,
  parameter int DW         = 16,
  parameter int AW         = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_fall,
  input  logic                  frame_done,
  input  uw_op_e                op,
  input  logic [ADDR_SLOTS-1:0] field,
  input  logic [DW-1:0]         wdata,
  input  logic                  busy,
  output logic                  wen,
  output logic                  launch,
  output logic                  clr_all,
  output logic                  wr_en,
  output logic [AW-1:0]         wr_addr,
  output logic [DW-1:0]         wr_data
);
  uw_ext_e ext;
  uw_act_e act;
  logic    set_wen, clr_wen;

  assign ext = uw_ext_e'(field[ADDR_SLOTS-1 -: 2]);

  always_comb begin
    set_wen = 1'b0;
    clr_wen = 1'b0;
    act     = ACT_NONE;
    if (cs_fall && frame_done && !busy) begin
      unique case (op)
        OP_EXT: begin
          unique case (ext)
            EXT_UNLOCK: set_wen = 1'b1;
            EXT_LOCK:   clr_wen = 1'b1;
            EXT_WIPE:   act     = ACT_ERASE_ALL;
            default:    act     = ACT_NONE;
          endcase
        end
        OP_ERASE: act = ACT_ERASE_ONE;
        OP_WRITE: act = ACT_WRITE;
        default:  act = ACT_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wen <= 1'b0;
    else if (set_wen) wen <= 1'b1;
    else if (clr_wen) wen <= 1'b0;
  end

  assign launch  = wen && (act != ACT_NONE);
  assign clr_all = launch && (act == ACT_ERASE_ALL);
  assign wr_en   = launch && (act == ACT_ERASE_ONE || act == ACT_WRITE);
  assign wr_addr = field[AW-1:0];
  assign wr_data = (act == ACT_WRITE) ? wdata : '1;
endmodule

// File: rtl/uw_busy_timer.sv
module uw_busy_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (launch)         remain <= CW'(CYCLES);
    else if (remain != '0)   remain <= remain - CW'(1);
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/uw_word_array.sv
module uw_word_array #(
  parameter int WORDS = 128,
  parameter int DW    = 16,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                mem[g] <= '0;
      else if (clr_all)                          mem[g] <= '1;
      else if (wr_en && wr_addr == AW'(g))       mem[g] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/uw_eeprom_ctrl.sv
module uw_eeprom_ctrl
  import uw_pkg::*;
#(
  parameter int WORDS        = 128,
  parameter int DW           = 16,
  parameter int ADDR_SLOTS   = 8,
  parameter int ERASE_CYCLES = 5000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_bit,
  output logic do_oe
);
  localparam int AW = $clog2(WORDS);

  logic                  cs_s, di_s, sk_rise, cs_rise, cs_fall;
  logic                  frame_done, start_seen, rd_active, rd_bit;
  uw_op_e                op;
  logic [ADDR_SLOTS-1:0] field;
  logic [DW-1:0]         wdata, rd_word, wr_data;
  logic                  wen, launch, clr_all, wr_en, busy;
  logic [AW-1:0]         wr_addr;
  logic                  stat_armed, stat_mode;

  uw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .cs_o(cs_s), .di_o(di_s), .sk_rise(sk_rise), .cs_rise(cs_rise), .cs_fall(cs_fall)
  );

  uw_frame_rx #(.ADDR_SLOTS(ADDR_SLOTS), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sk_rise(sk_rise), .di_s(di_s),
    .busy(busy), .rd_word(rd_word), .frame_done(frame_done), .op(op),
    .field(field), .wdata(wdata), .start_seen(start_seen),
    .rd_active(rd_active), .rd_bit(rd_bit)
  );

  uw_cmd_exec #(.ADDR_SLOTS(ADDR_SLOTS), .DW(DW), .AW(AW)) u_exec (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .frame_done(frame_done),
    .op(op), .field(field), .wdata(wdata), .busy(busy), .wen(wen),
    .launch(launch), .clr_all(clr_all), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  uw_busy_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy)
  );

  uw_word_array #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(field[AW-1:0]),
    .rd_data(rd_word)
  );

  // Status presentation: armed by a committed array change, shown on the next cs rise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_armed <= 1'b0;
      stat_mode  <= 1'b0;
      do_oe      <= 1'b0;
      do_bit     <= 1'b0;
    end else begin
      if (launch)       stat_armed <= 1'b1;
      else if (cs_rise) stat_armed <= 1'b0;
      if (!cs_s || start_seen) stat_mode <= 1'b0;
      else if (cs_rise)        stat_mode <= stat_armed;
      do_oe  <= cs_s && (rd_active || stat_mode);
      do_bit <= rd_active ? rd_bit : !busy;
    end
  end
endmodule

// File: rtl/uw_eeprom_chk.sv
module uw_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic do_oe,
  input logic wen,
  input logic launch,
  input logic busy,
  input logic clr_all,
  input logic wr_en
);
  AST_NO_CHANGE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all || wr_en) |-> wen); // R1
  AST_COMMIT_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !cs_s); // R6
  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy); // R8
  AST_DO_HIZ_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !do_oe); // R9
  AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch); // R12
endmodule

bind uw_eeprom_ctrl uw_eeprom_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .do_oe(do_oe), .wen(wen),
  .launch(launch), .busy(busy), .clr_all(clr_all), .wr_en(wr_en)
);

// File: tb/test_uw_eeprom_ctrl.sv
module test_uw_eeprom_ctrl;
  localparam int BUSY_CYC = 60;
  localparam int HP       = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_bit, do_oe;

  int n_vec = 0, n_bad = 0;
  logic [15:0] model [128];
  bit wen_m = 1'b0;

  always #2 clk = ~clk;

  uw_eeprom_ctrl #(.ERASE_CYCLES(BUSY_CYC)) i_uw_eeprom_ctrl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .do_bit(do_bit), .do_oe(do_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b);
    di = b; tick(HP); sk = 1'b1; tick(HP); sk = 1'b0;
  endtask

  task automatic frame(input logic [1:0] op, input logic [7:0] a);
    cs = 1'b1; tick(HP);
    clk_bit(1'b1);
    for (int i = 1; i >= 0; i--) clk_bit(op[i]);
    for (int i = 7; i >= 0; i--) clk_bit(a[i]);
  endtask

  task automatic end_cmd;
    tick(HP); cs = 1'b0; tick(HP);
  endtask

  function automatic bit will_commit();
    return wen_m;
  endfunction

  // raise cs after a command and check the ready/busy status
  task automatic status(input bit launched, input string req);
    cs = 1'b1; tick(6);
    if (launched) begin
      chk({req, " R8 busy oe"}, 32'(do_oe), 32'd1);
      chk({req, " R8 busy low"}, 32'(do_bit), 32'd0);
      tick(BUSY_CYC + 10);
      chk({req, " R8 ready high"}, 32'(do_bit), 32'd1);
    end else begin
      chk({req, " R1 no status"}, 32'(do_oe), 32'd0);
    end
    cs = 1'b0; tick(HP);
  endtask

  task automatic ext_cmd(input logic [1:0] code);
    frame(2'b00, {code, 6'b101010});
    end_cmd();
    if (code == 2'b11) wen_m = 1'b1;
    if (code == 2'b00) wen_m = 1'b0;
    if (code == 2'b10 && wen_m) for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;
  endtask

  task automatic erase_cmd(input logic [7:0] a);
    bit l;
    frame(2'b11, a);
    chk("R9 oe low during frame", 32'(do_oe), 32'd0);
    end_cmd();
    l = will_commit();
    if (l) model[a[6:0]] = 16'hFFFF;
    status(l, "R5");
  endtask

  task automatic write_cmd(input logic [7:0] a, input logic [15:0] d);
    bit l;
    frame(2'b01, a);
    for (int i = 15; i >= 0; i--) clk_bit(d[i]);
    chk("R9 oe low during write frame", 32'(do_oe), 32'd0);
    end_cmd();
    l = will_commit();
    if (l) model[a[6:0]] = d;
    status(l, "R13");
  endtask

  task automatic read_chk(input logic [7:0] a, input string req);
    logic [15:0] got;
    got = '0;
    frame(2'b10, a);
    chk({req, " R11 dummy oe"}, 32'(do_oe), 32'd1);
    chk({req, " R11 dummy zero"}, 32'(do_bit), 32'd0);
    for (int i = 0; i < 16; i++) begin
      clk_bit(1'b0);
      got = {got[14:0], do_bit};
    end
    end_cmd();
    chk({req, " read word"}, 32'(got), 32'(model[a[6:0]]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 16'h0000;
    void'($urandom(32'h00C0FFEE));
    tick(5); rst_n = 1'b1; tick(5);

    chk("R9 reset oe", 32'(do_oe), 32'd0);
    read_chk(8'h03, "R13 reset zero");
    // R1: locked after reset
    erase_cmd(8'h03);
    write_cmd(8'h04, 16'h1234);
    ext_cmd(2'b10);
    read_chk(8'h03, "R1 erase ignored");
    read_chk(8'h04, "R1 write ignored");
    read_chk(8'h70, "R1 eral ignored");
    // R3 / R13: unlock, write, R2 leading zeros before start
    ext_cmd(2'b11);
    write_cmd(8'h04, 16'hA5C3);
    write_cmd(8'h05, 16'h0F0F);
    cs = 1'b1; tick(HP); clk_bit(1'b0); clk_bit(1'b0);
    frame(2'b01, 8'h06);
    for (int i = 15; i >= 0; i--) clk_bit(1'(16'h3C5A >> i));
    end_cmd(); model[6] = 16'h3C5A; status(1'b1, "R2");
    read_chk(8'h04, "R13 write");
    read_chk(8'h06, "R2 leading zeros");
    // R5 single erase, neighbour intact
    erase_cmd(8'h04);
    read_chk(8'h04, "R5 erased");
    read_chk(8'h05, "R5 neighbour");
    // R10 wrap: A7 ignored
    write_cmd(8'h07, 16'h7777);
    erase_cmd(8'h87);
    read_chk(8'h07, "R10 wrap");
    // R7 partial frame discarded
    write_cmd(8'h09, 16'hBEEF);
    cs = 1'b1; tick(HP); clk_bit(1'b1); clk_bit(1'b1); clk_bit(1'b1);
    clk_bit(1'b0); clk_bit(1'b0); end_cmd();
    status(1'b0, "R7");
    read_chk(8'h09, "R7 partial erase dropped");
    // R12 commands during busy ignored (lock attempt)
    frame(2'b11, 8'h09);
    end_cmd();
    model[9] = 16'hFFFF;
    frame(2'b00, 8'h00);
    end_cmd();
    tick(BUSY_CYC + 10);
    write_cmd(8'h0A, 16'h5151);
    read_chk(8'h0A, "R12 lock during busy ignored");
    // R3 lock, R11 read while locked
    ext_cmd(2'b00);
    erase_cmd(8'h0A);
    read_chk(8'h0A, "R3 locked erase ignored");
    // R4 erase-all
    ext_cmd(2'b11);
    ext_cmd(2'b10);
    status(1'b1, "R4");
    read_chk(8'h00, "R4 word 0");
    read_chk(8'h7F, "R4 word 127");
    read_chk(8'h05, "R4 word 5");
    // constrained random mix
    for (int it = 0; it < 40; it++) begin
      int kind;
      logic [7:0] a;
      logic [15:0] d;
      kind = int'($urandom % 6);
      a = 8'($urandom);
      d = 16'($urandom);
      case (kind)
        0: ext_cmd(2'b11);
        1: ext_cmd(2'b00);
        2: erase_cmd(a);
        3, 4: write_cmd(a, d);
        default: read_chk(a, "R6 random");
      endcase
    end
    for (int i = 0; i < 8; i++) read_chk(8'(i * 17), "R6 final sweep");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule